// File: doc/BRIEF.md
# Thermal Inkjet Nozzle Fire Sequencer

This block drives the firing waveforms of a thermal inkjet head. The head's nozzles are wired as a matrix. A set of active-low group lines picks one row of nozzles. A set of primitive lines then heats the chosen nozzles in that row. On a fire trigger the block takes a snapshot of a nozzle bitmap and five 8-bit timing fields. It then sweeps the group lines in ascending order. Each group stays selected for its whole firing window. While a group is selected, its primitive lines carry a short warming pulse and then the main firing pulse, but only for the nozzles whose bitmap bit is set.

The firing window of every group has the same shape. It starts with a lead-in wait, then the warming pulse, then a pause, then the firing pulse, and ends with a trailing wait. Each part lasts as many system clocks as its timing field says. While a sweep runs, the block enables the head, turns its bias on and asks the head for a fault check. It watches a print-ready input, and a fault on that input stops the sweep at once. At the end of a sweep, a done flag and an error bit report how the sweep finished. A trigger that arrives during a sweep is ignored and is recorded in a sticky flag.

Top module: `fire_seq`

## Requirements
- R1: After reset all group lines are high, all primitive lines are low, the head-enable, bias-off and fault-test outputs are high, and busy, done, error and overrun are low.
- R2: An accepted trigger selects group 0 in the next cycle. Groups then follow in ascending order up to GROUPS-1. Each group is low for exactly L = front + pre + gap' + fire + back cycles, where gap' is gap when pre is nonzero and 0 otherwise. If that sum is zero, L is 1. At no time is more than one group line low.
- R3: Inside a group's window, with cycles counted from 0, the primitive lines equal that group's mask slice during cycles [front, front+pre) and [front+pre+gap', front+pre+gap'+fire). They are zero in every other cycle. Group g uses mask bits g*PRIMS to g*PRIMS+PRIMS-1, and mask bit g*PRIMS+i drives primitive line i.
- R4: A pre-heat field of zero removes both the warming pulse and the pause. The firing pulse then starts at cycle front of the window, whatever the gap field holds.
- R5: While a sweep runs, head-enable (active low), bias-off (high = bias off) and fault-test (active low) are all 0. When idle they are all 1.
- R6: A trigger sampled while busy does not restart or change the sweep. It sets the overrun flag, which stays set until reset.
- R7: If print-ready is low at a clock edge while busy, then from the next cycle the sweep stops. All group lines go high, all primitive lines go low, and done and error both read 1.
- R8: When the last group's window completes, busy drops and done reads 1 with error 0. An accepted trigger clears done and error.
- R9: The mask and timing fields are captured at the accepted trigger. Changing them during a sweep does not affect that sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| fire_i | input | 1 | Fire trigger, sampled each edge |
| ok2print_i | input | 1 | Print-ready status, low means head fault |
| mask_i | input | GROUPS*PRIMS | Nozzle bitmap, one PRIMS-bit slice per group |
| t_front_i | input | 8 | Lead-in wait in clocks |
| t_pre_i | input | 8 | Warming pulse width in clocks (0 = skip pulse and pause) |
| t_gap_i | input | 8 | Pause between warming and firing pulse |
| t_fire_i | input | 8 | Firing pulse width in clocks |
| t_back_i | input | 8 | Trailing wait in clocks |
| grp_n_o | output | GROUPS | Group select lines, active low |
| prim_o | output | PRIMS | Primitive heat lines, active high |
| head_en_n_o | output | 1 | Head enable, active low |
| bias_off_o | output | 1 | Head bias off when high |
| fault_test_n_o | output | 1 | Fault check request, active low |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | Last sweep ended |
| err_o | output | 1 | Last sweep stopped on a fault |
| overrun_o | output | 1 | Sticky: trigger arrived during a sweep |

## Verification
The bench builds the block with its default 13 groups and 16 primitive lines. Every one of the 208 mask bits is therefore in play, and the sweep has to walk all the way to the highest group index, so the final-group completion path is exercised. The timing fields are kept small so that several complete sweeps fit in the run. They cover four cases: one with every phase present, one with a zero pre-heat and a nonzero gap that must be ignored, one with every field zero so that each window shrinks to a single cycle, and one that is cut short by a head fault.

// File: rtl/fs_pkg.sv
package fs_pkg;

    localparam int NOZ_GROUPS = 13;
    localparam int NOZ_PRIMS  = 16;
    localparam int TIME_W     = 8;
    localparam int CNT_W      = TIME_W + 3;

    typedef struct packed {
        logic [TIME_W-1:0] front;
        logic [TIME_W-1:0] pre;
        logic [TIME_W-1:0] gap;
        logic [TIME_W-1:0] fire;
        logic [TIME_W-1:0] back;
    } timing_t;

    typedef enum logic [2:0] {
        PH_FRONT,
        PH_PRE,
        PH_GAP,
        PH_FIRE,
        PH_BACK
    } phase_e;

    function automatic logic [CNT_W-1:0] widen(input logic [TIME_W-1:0] v);
        return {{(CNT_W-TIME_W){1'b0}}, v};
    endfunction

endpackage

// File: rtl/fs_window.sv
module fs_window
    import fs_pkg::*;
(
    input  timing_t           tim_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output phase_e            phase_o,
    output logic              last_o
);

    logic [CNT_W-1:0] end_front;
    logic [CNT_W-1:0] end_pre;
    logic [CNT_W-1:0] end_gap;
    logic [CNT_W-1:0] end_fire;
    logic [CNT_W-1:0] end_all;

    always_comb begin
        end_front = widen(tim_i.front);
        end_pre   = end_front + widen(tim_i.pre);
        end_gap   = end_pre + ((tim_i.pre == '0) ? '0 : widen(tim_i.gap));
        end_fire  = end_gap + widen(tim_i.fire);
        end_all   = end_fire + widen(tim_i.back);
    end

    always_comb begin
        if (cnt_i < end_front)     phase_o = PH_FRONT;
        else if (cnt_i < end_pre)  phase_o = PH_PRE;
        else if (cnt_i < end_gap)  phase_o = PH_GAP;
        else if (cnt_i < end_fire) phase_o = PH_FIRE;
        else                       phase_o = PH_BACK;
    end

    assign last_o = (end_all == '0) ? 1'b1 : (cnt_i == end_all - 1'b1);

endmodule

// File: rtl/fs_sweep.sv
module fs_sweep #(
    parameter  int GROUPS = 13,
    parameter  int CW     = 11,
    localparam int GW     = $clog2(GROUPS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          abort_i,
    input  logic          last_i,
    output logic          busy_o,
    output logic [GW-1:0] grp_o,
    output logic [CW-1:0] cnt_o,
    output logic          finish_o
);

    localparam logic [GW-1:0] LAST_GRP = GW'(GROUPS - 1);

    assign finish_o = busy_o && !abort_i && last_i && (grp_o == LAST_GRP);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_o <= 1'b0;
            grp_o  <= '0;
            cnt_o  <= '0;
        end else if (!busy_o) begin
            if (start_i) begin
                busy_o <= 1'b1;
                grp_o  <= '0;
                cnt_o  <= '0;
            end
        end else if (abort_i) begin
            busy_o <= 1'b0;
        end else if (last_i) begin
            cnt_o <= '0;
            if (grp_o == LAST_GRP) begin
                busy_o <= 1'b0;
            end else begin
                grp_o <= grp_o + 1'b1;
            end
        end else begin
            cnt_o <= cnt_o + 1'b1;
        end
    end

endmodule

// File: rtl/fs_drive.sv
module fs_drive #(
    parameter  int GROUPS = 13,
    parameter  int PRIMS  = 16,
    localparam int GW     = $clog2(GROUPS),
    localparam int MW     = GROUPS * PRIMS
) (
    input  logic              busy_i,
    input  logic [GW-1:0]     grp_i,
    input  logic              heat_i,
    input  logic [MW-1:0]     mask_i,
    output logic [GROUPS-1:0] grp_n_o,
    output logic [PRIMS-1:0]  prim_o
);

    logic [PRIMS-1:0] row;

    for (genvar g = 0; g < GROUPS; g++) begin : g_sel
        assign grp_n_o[g] = !(busy_i && (grp_i == GW'(g)));
    end

    always_comb begin
        row = '0;
        for (int g = 0; g < GROUPS; g++) begin
            if (grp_i == GW'(g)) row = mask_i[g*PRIMS +: PRIMS];
        end
    end

    assign prim_o = (busy_i && heat_i) ? row : '0;

endmodule

// File: rtl/fire_seq.sv
module fire_seq
    import fs_pkg::*;
#(
    parameter  int GROUPS = NOZ_GROUPS,
    parameter  int PRIMS  = NOZ_PRIMS,
    localparam int GW     = $clog2(GROUPS),
    localparam int MW     = GROUPS * PRIMS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire_i,
    input  logic              ok2print_i,
    input  logic [MW-1:0]     mask_i,
    input  logic [TIME_W-1:0] t_front_i,
    input  logic [TIME_W-1:0] t_pre_i,
    input  logic [TIME_W-1:0] t_gap_i,
    input  logic [TIME_W-1:0] t_fire_i,
    input  logic [TIME_W-1:0] t_back_i,
    output logic [GROUPS-1:0] grp_n_o,
    output logic [PRIMS-1:0]  prim_o,
    output logic              head_en_n_o,
    output logic              bias_off_o,
    output logic              fault_test_n_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic              overrun_o
);

    timing_t          tim_q;
    logic [MW-1:0]    mask_q;
    logic             busy;
    logic [GW-1:0]    grp;
    logic [CNT_W-1:0] cnt;
    logic             last;
    logic             finish;
    phase_e           phase;
    logic             start;
    logic             abort;
    logic             heat;

    assign start = fire_i && !busy;
    assign abort = busy && !ok2print_i;
    assign heat  = (phase == PH_PRE) || (phase == PH_FIRE);

    always_ff @(posedge clk) begin
        if (rst) begin
            tim_q  <= '0;
            mask_q <= '0;
        end else if (start) begin
            tim_q  <= '{front: t_front_i, pre: t_pre_i, gap: t_gap_i,
                        fire: t_fire_i, back: t_back_i};
            mask_q <= mask_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_o    <= 1'b0;
            err_o     <= 1'b0;
            overrun_o <= 1'b0;
        end else begin
            if (busy && fire_i) overrun_o <= 1'b1;
            if (start) begin
                done_o <= 1'b0;
                err_o  <= 1'b0;
            end else if (abort) begin
                done_o <= 1'b1;
                err_o  <= 1'b1;
            end else if (finish) begin
                done_o <= 1'b1;
                err_o  <= 1'b0;
            end
        end
    end

    fs_window u_win (
        .tim_i   (tim_q),
        .cnt_i   (cnt),
        .phase_o (phase),
        .last_o  (last)
    );

    fs_sweep #(.GROUPS(GROUPS), .CW(CNT_W)) u_sweep (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start),
        .abort_i  (abort),
        .last_i   (last),
        .busy_o   (busy),
        .grp_o    (grp),
        .cnt_o    (cnt),
        .finish_o (finish)
    );

    fs_drive #(.GROUPS(GROUPS), .PRIMS(PRIMS)) u_drive (
        .busy_i  (busy),
        .grp_i   (grp),
        .heat_i  (heat),
        .mask_i  (mask_q),
        .grp_n_o (grp_n_o),
        .prim_o  (prim_o)
    );

    assign busy_o         = busy;
    assign head_en_n_o    = !busy;
    assign bias_off_o     = !busy;
    assign fault_test_n_o = !busy;

endmodule

// File: rtl/fs_chk.sv
module fs_chk #(
    parameter int GROUPS = 13,
    parameter int PRIMS  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              fire_i,
    input logic              ok2print_i,
    input logic [GROUPS-1:0] grp_n_o,
    input logic [PRIMS-1:0]  prim_o,
    input logic              head_en_n_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              err_o,
    input logic              overrun_o
);

    localparam logic [GROUPS-1:0] ALL_HI = {GROUPS{1'b1}};

    // R2
    one_group_low_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~grp_n_o));

    // R3
    prim_inside_group_chk: assert property (@(posedge clk) disable iff (rst)
        (prim_o != '0) |-> (grp_n_o != ALL_HI));

    // R5
    head_on_with_group_chk: assert property (@(posedge clk) disable iff (rst)
        (grp_n_o != ALL_HI) |-> !head_en_n_o);

    // R6
    overrun_set_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && fire_i) |=> overrun_o);

    // R6
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        overrun_o |=> overrun_o);

    // R7
    fault_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !ok2print_i) |=>
            (!busy_o && done_o && err_o && grp_n_o == ALL_HI && prim_o == '0));

    // R8
    start_clears_done_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && fire_i) |=> (busy_o && !done_o && !err_o));

endmodule

bind fire_seq fs_chk #(.GROUPS(GROUPS), .PRIMS(PRIMS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .fire_i      (fire_i),
    .ok2print_i  (ok2print_i),
    .grp_n_o     (grp_n_o),
    .prim_o      (prim_o),
    .head_en_n_o (head_en_n_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .overrun_o   (overrun_o)
);

// File: tb/sim_fire_seq.sv
`timescale 1ns/1ps
module sim_fire_seq;

    localparam int G  = 13;
    localparam int P  = 16;
    localparam int MW = G * P;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          fire = 1'b0;
    logic          ok = 1'b1;
    logic [MW-1:0] mask = '0;
    logic [7:0]    tf = '0, tp = '0, tg = '0, tw = '0, tb = '0;

    logic [G-1:0]  grp_n;
    logic [P-1:0]  prim;
    logic          head_en_n, bias_off, fault_test_n, busy, done, err, ovr;

    always #2.5 clk = ~clk;

    fire_seq #(.GROUPS(G), .PRIMS(P)) u0 (
        .clk(clk), .rst(rst), .fire_i(fire), .ok2print_i(ok), .mask_i(mask),
        .t_front_i(tf), .t_pre_i(tp), .t_gap_i(tg), .t_fire_i(tw), .t_back_i(tb),
        .grp_n_o(grp_n), .prim_o(prim), .head_en_n_o(head_en_n),
        .bias_off_o(bias_off), .fault_test_n_o(fault_test_n),
        .busy_o(busy), .done_o(done), .err_o(err), .overrun_o(ovr)
    );

    int    checks = 0;
    int    errors = 0;
    bit    finished = 1'b0;
    string ptag = "R3";

    // behavioural reference state
    int            m_busy = 0, m_grp = 0, m_cnt = 0;
    int            m_done = 0, m_err = 0, m_ovr = 0;
    int            mf = 0, mp = 0, mg = 0, mw = 0, mb = 0;
    logic [MW-1:0] m_mask = '0;

    function automatic int win_len();
        int l;
        l = mf + mp + ((mp != 0) ? mg : 0) + mw + mb;
        return (l == 0) ? 1 : l;
    endfunction

    function automatic logic [MW-1:0] mk(input int s);
        logic [MW-1:0] m;
        for (int i = 0; i < MW; i++) m[i] = ((i * s + i / 5) % 7) < 3;
        return m;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_grp = 0; m_cnt = 0;
            m_done = 0; m_err = 0; m_ovr = 0;
        end else if (m_busy == 0) begin
            if (fire) begin
                m_busy = 1; m_grp = 0; m_cnt = 0; m_done = 0; m_err = 0;
                mf = tf; mp = tp; mg = tg; mw = tw; mb = tb; m_mask = mask;
            end
        end else begin
            if (fire) m_ovr = 1;
            if (!ok) begin
                m_busy = 0; m_done = 1; m_err = 1;
            end else if (m_cnt == win_len() - 1) begin
                m_cnt = 0;
                if (m_grp == G - 1) begin
                    m_busy = 0; m_done = 1; m_err = 0;
                end else begin
                    m_grp++;
                end
            end else begin
                m_cnt++;
            end
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !finished) begin
            logic [G-1:0] eg;
            logic [P-1:0] ep;
            int pe, ge, fe;
            bit heat;
            eg = '1;
            if (m_busy != 0) eg[m_grp] = 1'b0;
            pe = mf + mp;
            ge = pe + ((mp != 0) ? mg : 0);
            fe = ge + mw;
            heat = (m_cnt >= mf && m_cnt < pe) || (m_cnt >= ge && m_cnt < fe);
            ep = (m_busy != 0 && heat) ? m_mask[m_grp*P +: P] : '0;
            chk("R2", "group lines", 32'(grp_n), 32'(eg));
            chk(ptag, "primitive lines", 32'(prim), 32'(ep));
            chk("R5", "head enable", 32'(head_en_n), 32'(m_busy == 0));
            chk("R5", "bias off", 32'(bias_off), 32'(m_busy == 0));
            chk("R5", "fault test", 32'(fault_test_n), 32'(m_busy == 0));
            chk("R8", "done", 32'(done), 32'(m_done));
            chk("R7", "error", 32'(err), 32'(m_err));
            chk("R6", "overrun", 32'(ovr), 32'(m_ovr));
        end
    end

    task automatic pulse_fire();
        @(negedge clk); #1 fire = 1'b1;
        @(negedge clk); #1 fire = 1'b0;
    endtask

    task automatic set_t(input int f, input int p, input int g, input int w, input int b);
        tf = 8'(f); tp = 8'(p); tg = 8'(g); tw = 8'(w); tb = 8'(b);
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (m_busy != 0);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "group lines after reset", 32'(grp_n), 32'(13'h1fff));
        chk("R1", "primitive lines after reset", 32'(prim), 32'h0);
        chk("R1", "head/bias/fault after reset", {29'h0, head_en_n, bias_off, fault_test_n}, 32'h7);
        chk("R1", "flags after reset", {28'h0, busy, done, err, ovr}, 32'h0);

        // full phase set
        set_t(2, 3, 1, 4, 2); mask = mk(7);
        pulse_fire();
        chk("R2", "busy after trigger", 32'(busy), 32'h1);
        chk("R2", "group 0 first", 32'(grp_n), 32'(13'h1ffe));
        wait_idle();
        chk("R8", "clean completion done/err", {30'h0, done, err}, 32'h2);

        // capture and overrun
        set_t(1, 2, 2, 3, 1); mask = mk(11);
        pulse_fire();
        chk("R8", "trigger clears done", 32'(done), 32'h0);
        repeat (20) @(negedge clk);
        ptag = "R9";
        #1 mask = mk(3); set_t(5, 5, 5, 5, 5);
        pulse_fire();
        chk("R6", "overrun raised", 32'(ovr), 32'h1);
        chk("R6", "sweep not restarted", 32'(busy), 32'h1);
        wait_idle();
        ptag = "R3";

        // zero pre-heat skips gap
        ptag = "R4";
        set_t(1, 0, 5, 2, 0); mask = mk(5);
        pulse_fire();
        @(negedge clk);
        chk("R4", "fire pulse starts at front", 32'(prim), 32'(mask[P-1:0]));
        wait_idle();

        // all fields zero
        ptag = "R3";
        set_t(0, 0, 0, 0, 0); mask = '1;
        pulse_fire();
        chk("R3", "no heat with empty window", 32'(prim), 32'h0);
        wait_idle();
        chk("R2", "single-cycle windows finish", 32'(done), 32'h1);

        // fault abort
        set_t(2, 2, 2, 2, 2); mask = mk(13);
        pulse_fire();
        repeat (30) @(negedge clk);
        #1 ok = 1'b0;
        @(negedge clk);
        chk("R7", "abort done/err", {30'h0, done, err}, 32'h3);
        chk("R7", "abort releases groups", 32'(grp_n), 32'(13'h1fff));
        #1 ok = 1'b1;
        repeat (3) @(negedge clk);
        chk("R6", "overrun still sticky", 32'(ovr), 32'h1);

        finish_run();
    end

endmodule